// File: doc/BRIEF.md
# Interrupt Moderation Threshold Timer

This block holds back an interrupt until a programmed number of microseconds has passed. It counts timing ticks up to a threshold, flags the event in a sticky status bit, and gives a one-cycle expiry pulse that a nearby interrupt aggregator can use to release coalesced causes. Ticks come from an internal prescaler that produces one pulse per microsecond from the core clock. A control bit can instead select an external tick strobe.

Software programs the block through a small word-addressed register port with three registers: threshold, live count and control. Writes to the threshold are limited to a 5,000,000 µs ceiling. In one-shot mode the count stops at the threshold. In free-running mode it wraps to zero and fires again on every period. A self-clearing control bit restarts the count and drops the status flag.

Top module: `itr_mod_timer`

## Requirements
- R1: After reset the threshold reads 300, the count reads 0, the control word reads 0 and `expired_o` is low.
- R2: Address 0 is the threshold, address 1 the live count, address 2 control, and address 3 reads 0. A threshold write above 5,000,000 stores 5,000,000.
- R3: Control bit 0 enables counting. While it is clear the count holds its value whatever ticks arrive.
- R4: With control bit 1 clear, the count advances once per CLK_MHZ clock cycles, driven by the internal prescaler.
- R5: With control bit 1 set, every clock cycle in which `ext_tick_i` is high advances the count by one. With bit 1 clear, `ext_tick_i` has no effect.
- R6: With control bit 2 clear (one-shot), the count stops at the threshold and ignores further ticks.
- R7: With control bit 2 set (free-running), the tick that brings the count to the threshold resets it to 0, and counting carries on.
- R8: `expired_o` is high for exactly one cycle on each tick that reaches the threshold. It rises on the same clock edge as the count update.
- R9: Control bit 4 reads 1 once the threshold has been reached. Writes to bit 4 do not change it. Only a clear resets it.
- R10: Writing 1 to control bit 3 sets the count to 0 and clears bit 4, and this takes priority over a tick on the same edge. Bit 3 always reads 0.
- R11: Writes to address 1 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ext_tick_i | input | 1 | External tick strobe, one count per high cycle |
| expired_o | output | 1 | One-cycle pulse when the threshold is reached |

## Verification
The bench builds the block with CLK_MHZ set to 4, so every window of four cycles holds exactly one internal tick. This lets the bench check the internal tick rate exactly, whatever the prescaler phase is. The default threshold and the saturation ceiling stay at their full values, because only reads and writes of those values are checked. Threshold behaviour is exercised with small thresholds and the external tick, so one-shot hold, free-running wrap, pulse counts and clear-versus-tick priority all fall within a few dozen cycles.

// File: rtl/itr_mod_pkg.sv
package itr_mod_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    ADDR_THRESH = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_RSVD   = 2'd3
  } itr_addr_e;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_EXT   = 1;
  localparam int unsigned CB_FREE  = 2;
  localparam int unsigned CB_CLR   = 3;
  localparam int unsigned CB_REACH = 4;

  typedef struct packed {
    logic free_run;
    logic ext_sel;
    logic en;
  } itr_ctrl_t;
endpackage

// File: rtl/itr_tick_gen.sv
module itr_tick_gen #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end

      assign tick_o = (pre_q == LAST);

      // R4: a tick never lasts two cycles when dividing
      a_r4_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/itr_mod_regs.sv
module itr_mod_regs
  import itr_mod_pkg::*;
#(
  parameter int unsigned RW         = REG_W,
  parameter int unsigned THRESH_MAX = 5_000_000,
  parameter int unsigned THRESH_RST = 300
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] thresh_o,
  output itr_ctrl_t     ctrl_o,
  output logic          clr_o
);
  localparam logic [RW-1:0] MAX_V = RW'(THRESH_MAX);
  localparam logic [RW-1:0] RST_V = RW'(THRESH_RST);

  logic wr_thr, wr_ctl;
  assign wr_thr = wr_en_i && (addr_i == ADDR_THRESH);
  assign wr_ctl = wr_en_i && (addr_i == ADDR_CTRL);
  assign clr_o  = wr_ctl && wdata_i[CB_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_o <= RST_V;
      ctrl_o   <= '0;
    end else begin
      if (wr_thr) thresh_o <= (wdata_i > MAX_V) ? MAX_V : wdata_i;
      if (wr_ctl) begin
        ctrl_o.en       <= wdata_i[CB_EN];
        ctrl_o.ext_sel  <= wdata_i[CB_EXT];
        ctrl_o.free_run <= wdata_i[CB_FREE];
      end
    end
  end

  // R2: stored threshold never exceeds the ceiling
  a_r2_thresh_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thresh_o <= MAX_V);
  // R2: oversize write lands exactly on the ceiling
  a_r2_thresh_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_thr && wdata_i > MAX_V) |=> thresh_o == MAX_V);
endmodule

// File: rtl/itr_mod_counter.sv
module itr_mod_counter
  import itr_mod_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] thresh_i,
  input  itr_ctrl_t     ctrl_i,
  input  logic          clr_i,
  input  logic          tick_int_i,
  input  logic          tick_ext_i,
  output logic [RW-1:0] count_o,
  output logic          reach_o,
  output logic          expired_o
);
  logic          tick_sel, at_lim, adv, hit;
  logic [RW:0]   nxt;

  always_comb begin
    tick_sel = ctrl_i.ext_sel ? tick_ext_i : tick_int_i;
    at_lim   = (count_o >= thresh_i);
    adv      = ctrl_i.en && tick_sel && (ctrl_i.free_run || !at_lim);
    nxt      = {1'b0, count_o} + 1'b1;
    hit      = adv && (nxt >= {1'b0, thresh_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '0;
      reach_o   <= 1'b0;
      expired_o <= 1'b0;
    end else if (clr_i) begin
      count_o   <= '0;
      reach_o   <= 1'b0;
      expired_o <= 1'b0;
    end else begin
      expired_o <= hit;
      if (hit) begin
        count_o <= ctrl_i.free_run ? '0 : thresh_i;
        reach_o <= 1'b1;
      end else if (adv) begin
        count_o <= nxt[RW-1:0];
      end
    end
  end

  // R3: disabled counter holds
  a_r3_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !clr_i) |=> $stable(count_o));
  // R6: one-shot counter parked at threshold stays there
  a_r6_oneshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.free_run && at_lim && !clr_i) |=> $stable(count_o));
  // R9: expiry pulse is always backed by the sticky flag
  a_r9_pulse_sets_reach: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> reach_o);
  // R9: flag falls only through a clear
  a_r9_reach_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reach_o && !clr_i) |=> reach_o);
  // R10: clear wins over everything
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0 && !reach_o && !expired_o));
  // R7: free-running wrap leaves zero behind the pulse
  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && ctrl_i.free_run && !clr_i) |=> count_o == '0);
endmodule

// File: rtl/itr_mod_timer.sv
module itr_mod_timer
  import itr_mod_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned THRESH_MAX = 5_000_000,
  parameter int unsigned THRESH_RST = 300
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        ext_tick_i,
  output logic        expired_o
);
  localparam int unsigned RW = REG_W;

  logic [RW-1:0] thresh, count;
  itr_ctrl_t     ctrl;
  logic          clr, reach, tick_int;

  itr_tick_gen #(.DIV(CLK_MHZ)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_int)
  );

  itr_mod_regs #(
    .RW(RW), .THRESH_MAX(THRESH_MAX), .THRESH_RST(THRESH_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .thresh_o (thresh),
    .ctrl_o   (ctrl),
    .clr_o    (clr)
  );

  itr_mod_counter #(.RW(RW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thresh_i   (thresh),
    .ctrl_i     (ctrl),
    .clr_i      (clr),
    .tick_int_i (tick_int),
    .tick_ext_i (ext_tick_i),
    .count_o    (count),
    .reach_o    (reach),
    .expired_o  (expired_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_THRESH: rdata_o = thresh;
      ADDR_COUNT:  rdata_o = count;
      ADDR_CTRL: begin
        rdata_o[CB_EN]    = ctrl.en;
        rdata_o[CB_EXT]   = ctrl.ext_sel;
        rdata_o[CB_FREE]  = ctrl.free_run;
        rdata_o[CB_REACH] = reach;
      end
      default: rdata_o = '0;
    endcase
  end

  // R11: count port write has no path into the counter
  a_r11_count_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_COUNT && !ctrl.en) |=> $stable(count));
endmodule

// File: tb/itr_mod_timer_tb_top.sv
`timescale 1ns/1ps
module itr_mod_timer_tb_top;
  localparam int unsigned CLK_MHZ = 4;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;
  localparam int NV = 36;

  // {kind, addr, data, expected}
  localparam logic [67:0] VEC [NV] = '{
    {K_RD, 2'd0, 32'd0,       32'd300},     // R1
    {K_RD, 2'd1, 32'd0,       32'd0},       // R1
    {K_RD, 2'd2, 32'd0,       32'd0},       // R1
    {K_RD, 2'd3, 32'd0,       32'd0},       // R2
    {K_WR, 2'd0, 32'd6000000, 32'd0},       // R2
    {K_RD, 2'd0, 32'd0,       32'd5000000}, // R2
    {K_WR, 2'd0, 32'd3,       32'd0},
    {K_RD, 2'd0, 32'd0,       32'd3},       // R2
    {K_WR, 2'd2, 32'h3,       32'd0},       // R3 R5
    {K_TK, 2'd0, 32'd2,       32'd0},
    {K_RD, 2'd1, 32'd0,       32'd2},       // R5
    {K_RD, 2'd2, 32'd0,       32'h3},       // R3
    {K_TK, 2'd0, 32'd1,       32'd0},
    {K_RD, 2'd1, 32'd0,       32'd3},       // R6
    {K_RD, 2'd2, 32'd0,       32'h13},      // R9
    {K_TK, 2'd0, 32'd4,       32'd0},
    {K_RD, 2'd1, 32'd0,       32'd3},       // R6
    {K_WR, 2'd1, 32'h55,      32'd0},       // R11
    {K_RD, 2'd1, 32'd0,       32'd3},       // R11
    {K_WR, 2'd2, 32'hB,       32'd0},       // R10
    {K_RD, 2'd1, 32'd0,       32'd0},       // R10
    {K_RD, 2'd2, 32'd0,       32'h3},       // R10
    {K_WR, 2'd2, 32'h7,       32'd0},       // R7
    {K_TK, 2'd0, 32'd3,       32'd0},
    {K_RD, 2'd1, 32'd0,       32'd0},       // R7
    {K_RD, 2'd2, 32'd0,       32'h17},      // R9
    {K_TK, 2'd0, 32'd2,       32'd0},
    {K_RD, 2'd1, 32'd0,       32'd2},       // R7
    {K_WR, 2'd2, 32'h6,       32'd0},       // R3
    {K_TK, 2'd0, 32'd5,       32'd0},
    {K_RD, 2'd1, 32'd0,       32'd2},       // R3
    {K_WR, 2'd2, 32'h3,       32'd0},       // R9
    {K_RD, 2'd2, 32'd0,       32'h13},      // R9
    {K_WR, 2'd2, 32'h8,       32'd0},       // R10
    {K_RD, 2'd2, 32'd0,       32'd0},       // R10
    {K_RD, 2'd1, 32'd0,       32'd0}        // R10
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ext_tick_i = 1'b0;
  logic        expired_o;

  int n_chk = 0, n_bad = 0, n_exp = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  itr_mod_timer #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_tick_i(ext_tick_i),
    .expired_o(expired_o)
  );

  always @(negedge clk_i) if (rst_ni && expired_o) n_exp++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    ext_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    ext_tick_i = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    check("R1 expired low in reset", {31'd0, expired_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k, a;
      logic [31:0] d, e;
      {k, a, d, e} = VEC[i];
      case (k)
        K_WR: wr(a, d);
        K_TK: ticks(int'(d));
        default: begin
          rd(a, r);
          check($sformatf("vector %0d", i), r, e);
        end
      endcase
    end

    // R7 R8: free-run, threshold 2, six ticks -> three single-cycle pulses
    wr(2'd0, 32'd2);
    wr(2'd2, 32'hF);
    n_exp = 0;
    ticks(6);
    @(negedge clk_i);
    check("R8 free-run pulse count", n_exp, 32'd3);
    rd(2'd1, r); check("R7 wrapped count", r, 32'd0);

    // R6 R8: one-shot, six ticks -> one pulse, parked at 2
    wr(2'd2, 32'hB);
    n_exp = 0;
    ticks(6);
    @(negedge clk_i);
    check("R8 one-shot pulse count", n_exp, 32'd1);
    rd(2'd1, r); check("R6 parked count", r, 32'd2);

    // R10: clear on the same edge as a tick
    wr(2'd0, 32'd100);
    wr(2'd2, 32'hB);
    ticks(5);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 32'hB; ext_tick_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; ext_tick_i = 1'b0;
    rd(2'd1, r); check("R10 clear beats tick", r, 32'd0);

    // R4: one internal tick per CLK_MHZ cycles
    wr(2'd2, 32'h9);
    repeat (CLK_MHZ) @(negedge clk_i);
    rd(2'd1, r); check("R4 internal tick rate", r, 32'd1);
    // R5: external strobe ignored while internal tick selected
    ticks(2 * CLK_MHZ);
    rd(2'd1, r); check("R5 ext ignored", r, 32'd3);

    // R1: reset mid-run restores defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(2'd0, r); check("R1 threshold after reset", r, 32'd300);
    rd(2'd1, r); check("R1 count after reset", r, 32'd0);
    rd(2'd2, r); check("R1 control after reset", r, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule